// File: doc/BRIEF.md
# Root Hub Downstream Port Status and Control Registers

This block holds the 16-bit status/control word of each downstream port of a full/low-speed USB root hub. Software reaches the ports through one write strobe and one read selector that carry a port index. Hardware events change the same words: a device attach (with a low-speed flag), a device detach, and a remote wakeup. The number of ports is a parameter (default two). Out of each word the block derives two outputs. The first is a one-cycle device-reset request per port. The second is a single controller-resume request.

Every word mixes three kinds of bit. The read-only bits (mask 0x01BB) follow hardware only. Two of them are change flags that software clears by writing 1. All other bits are plain read/write storage. Bit positions: 0 connected, 1 connect changed, 2 enabled, 3 enable changed, 6 resume detected, 7 always 1, 8 low-speed device, 9 port reset, 12 suspended. When a write and a hardware event reach the same port in the same cycle, the write is applied first and the event is applied on top of it.

Top module: `hub_port_regs`

## Requirements
- R1: After reset every implemented port reads 0x0080, and both request outputs are low.
- R2: A write to an implemented port loads the bits outside mask 0x01BB from the written data. The bits inside the mask are not changed by the write, except as R3 describes, and bit 7 always reads 1.
- R3: Writing 1 to bit 1 or bit 3 clears that bit. Writing 0 to either bit leaves it unchanged.
- R4: The port's device-reset request is high for exactly the one cycle after a write that meets three conditions: the write sets bit 9, bit 9 was 0 before the write, and bit 0 was 1. Any other write leaves the request low.
- R5: An attach sets bits 0 and 1 and copies the low-speed flag into bit 8. The resume request is high for the following cycle.
- R6: A detach clears bit 0 and sets bit 1 if bit 0 was 1. It clears bit 2 and sets bit 3 if bit 2 was 1. In either case the resume request is high for the following cycle.
- R7: A wakeup sets bit 6 and raises the resume request only when bit 12 is 1 and bit 6 is 0. Otherwise it has no effect on the word or on the resume request.
- R8: Reading a port index at or beyond the port count returns 0xFF7F. Writes and events addressed to such an index change no port and raise no request.
- R9: When a write and an attach or detach reach the same port in the same cycle, the change bits set by the event read 1, even if the write tried to clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Software write strobe |
| wr_port | input | IDX_W | Port index of the write |
| wr_data | input | 16 | Write data |
| rd_port | input | IDX_W | Port index of the read |
| rd_data | output | 16 | Read value for rd_port (combinational) |
| att_valid | input | 1 | Device attach event |
| att_port | input | IDX_W | Port index of the attach |
| att_low | input | 1 | Attached device is low speed |
| det_valid | input | 1 | Device detach event |
| det_port | input | IDX_W | Port index of the detach |
| wake_valid | input | 1 | Remote wakeup event |
| wake_port | input | IDX_W | Port index of the wakeup |
| dev_reset_req | output | NUM_PORTS | Per-port one-cycle device-reset request |
| resume_req | output | 1 | One-cycle controller-resume request |

## Verification
The assertions take for granted that an attach and a detach never reach the same port in the same cycle. Each event is a single-cycle strobe. The attach check depends on this rule, and so does the rule that a detach leaves the port disconnected. The random stimulus follows the rule: when both events pick the same port, the detach is dropped. Port indices, including indices beyond the port count, and all write data are otherwise left free.

// File: rtl/hub_port_pkg.sv
// Package: shared bit positions, masks and reset value of a downstream port word.
// Assumes a 16-bit word; positions are fixed because software decodes them.
package hub_port_pkg;
    localparam int WORD_W    = 16;
    localparam int B_CONN    = 0;
    localparam int B_CONN_CH = 1;
    localparam int B_EN      = 2;
    localparam int B_EN_CH   = 3;
    localparam int B_RESUME  = 6;
    localparam int B_LOWSPD  = 8;
    localparam int B_PRESET  = 9;
    localparam int B_SUSP    = 12;

    localparam logic [WORD_W-1:0] HW_ONLY_MASK = 16'h01BB;
    localparam logic [WORD_W-1:0] CLR_ON_ONE   = 16'h000A;
    localparam logic [WORD_W-1:0] WORD_INIT    = 16'h0080;
    localparam logic [WORD_W-1:0] ABSENT_VAL   = 16'hFF7F;
endpackage

// File: rtl/hub_port_word.sv
// Module: one downstream port word.
// Applies the software write first, then attach, detach and wakeup on top of it.
// Assumes attach and detach are never both asserted in one cycle.
module hub_port_word
    import hub_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              att_hit,
    input  logic              att_low,
    input  logic              det_hit,
    input  logic              wake_hit,
    output logic [WORD_W-1:0] word_o,
    output logic              rst_req_o,
    output logic              resume_o
);
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] after_wr;
    logic [WORD_W-1:0] after_att;
    logic [WORD_W-1:0] after_det;
    logic [WORD_W-1:0] word_d;
    logic              wake_ok;
    logic              rst_edge;

    // Software write: keep hardware-owned bits, load the rest, clear flags written with 1.
    always_comb begin
        after_wr = word_q;
        if (wr_hit) begin
            after_wr = (word_q & HW_ONLY_MASK) | (wr_data & ~HW_ONLY_MASK);
            after_wr = after_wr & ~(wr_data & CLR_ON_ONE);
        end
    end

    // Attach: mark connected, flag the change, record the device speed.
    always_comb begin
        after_att = after_wr;
        if (att_hit) begin
            after_att[B_CONN]    = 1'b1;
            after_att[B_CONN_CH] = 1'b1;
            after_att[B_LOWSPD]  = att_low;
        end
    end

    // Detach: drop connect and enable, flagging each change that happened.
    always_comb begin
        after_det = after_att;
        if (det_hit) begin
            if (after_att[B_CONN]) begin
                after_det[B_CONN]    = 1'b0;
                after_det[B_CONN_CH] = 1'b1;
            end
            if (after_att[B_EN]) begin
                after_det[B_EN]    = 1'b0;
                after_det[B_EN_CH] = 1'b1;
            end
        end
    end

    // Wakeup: note resume only on a suspended port without a pending resume.
    always_comb begin
        word_d  = after_det;
        wake_ok = wake_hit && after_det[B_SUSP] && !after_det[B_RESUME];
        if (wake_ok) begin
            word_d[B_RESUME] = 1'b1;
        end
    end

    // Reset request on a 0-to-1 write of the reset bit while a device is present.
    assign rst_edge = wr_hit && wr_data[B_PRESET] && !word_q[B_PRESET] && word_q[B_CONN];

    // State and request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q    <= WORD_INIT;
            rst_req_o <= 1'b0;
            resume_o  <= 1'b0;
        end else begin
            word_q    <= word_d;
            rst_req_o <= rst_edge;
            resume_o  <= att_hit || det_hit || wake_ok;
        end
    end

    assign word_o = word_q;

    // R4
    rst_req_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> ($past(word_q[B_PRESET]) == 1'b0) && word_q[B_PRESET] && $past(word_q[B_CONN]));
    // R2
    fixed_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_q[7] == 1'b1);
    // R5
    attach_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (att_hit && !det_hit) |=> word_q[B_CONN] && word_q[B_CONN_CH] && (word_q[B_LOWSPD] == $past(att_low)));
    // R6
    detach_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det_hit |=> !word_q[B_CONN] && !word_q[B_EN]);
    // R7
    wake_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(word_q[B_RESUME]) && !$past(wr_hit)) |-> $past(wake_hit) && $past(word_q[B_SUSP]));
endmodule

// File: rtl/hub_port_rdmux.sv
// Module: read selector over all port words.
// Returns the absent-port value for any index at or beyond NUM_PORTS.
module hub_port_rdmux
    import hub_port_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int IDX_W     = 3
) (
    input  logic [IDX_W-1:0]  sel,
    input  logic [WORD_W-1:0] words [NUM_PORTS],
    output logic [WORD_W-1:0] data_o
);
    // Pick the addressed word, default to the absent value.
    always_comb begin
        data_o = ABSENT_VAL;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (sel == IDX_W'(i)) begin
                data_o = words[i];
            end
        end
    end
endmodule

// File: rtl/hub_port_regs.sv
// Module: root hub downstream port register set (top).
// Decodes port indices for writes and events, instantiates one word per port,
// and merges the resume requests. Assumes 2**IDX_W >= NUM_PORTS.
module hub_port_regs
    import hub_port_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int IDX_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_port,
    input  logic [15:0]          wr_data,
    input  logic [IDX_W-1:0]     rd_port,
    output logic [15:0]          rd_data,
    input  logic                 att_valid,
    input  logic [IDX_W-1:0]     att_port,
    input  logic                 att_low,
    input  logic                 det_valid,
    input  logic [IDX_W-1:0]     det_port,
    input  logic                 wake_valid,
    input  logic [IDX_W-1:0]     wake_port,
    output logic [NUM_PORTS-1:0] dev_reset_req,
    output logic                 resume_req
);
    localparam int SLOTS = 1 << IDX_W;

    logic [WORD_W-1:0]    words [NUM_PORTS];
    logic [NUM_PORTS-1:0] resume_bits;

    initial begin
        if (SLOTS < NUM_PORTS) $display("hub_port_regs: IDX_W too small for NUM_PORTS");
    end

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        hub_port_word u_word (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (wr_en && (wr_port == IDX_W'(g))),
            .wr_data  (wr_data),
            .att_hit  (att_valid && (att_port == IDX_W'(g))),
            .att_low  (att_low),
            .det_hit  (det_valid && (det_port == IDX_W'(g))),
            .wake_hit (wake_valid && (wake_port == IDX_W'(g))),
            .word_o   (words[g]),
            .rst_req_o(dev_reset_req[g]),
            .resume_o (resume_bits[g])
        );
    end

    hub_port_rdmux #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_rdmux (
        .sel   (rd_port),
        .words (words),
        .data_o(rd_data)
    );

    // Any port asking for resume asks the controller.
    assign resume_req = |resume_bits;

    // R5 R6 R7 R8
    resume_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_req |-> $past(att_valid || det_valid || wake_valid));
endmodule

// File: tb/hub_port_regs_tb.sv
// Bench: behavioural reference model of the port words, compared every clock.
module hub_port_regs_tb_top;
    localparam int NP = 2;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 0, att_valid = 0, att_low = 0, det_valid = 0, wake_valid = 0;
    logic [IW-1:0] wr_port = 0, rd_port = 0, att_port = 0, det_port = 0, wake_port = 0;
    logic [15:0] wr_data = 0;
    logic [15:0] rd_data;
    logic [NP-1:0] dev_reset_req;
    logic resume_req;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;
    int model [NP];

    always #10 clk = ~clk;

    hub_port_regs #(.NUM_PORTS(NP), .IDX_W(IW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_port(wr_port), .wr_data(wr_data),
        .rd_port(rd_port), .rd_data(rd_data), .att_valid(att_valid), .att_port(att_port),
        .att_low(att_low), .det_valid(det_valid), .det_port(det_port),
        .wake_valid(wake_valid), .wake_port(wake_port),
        .dev_reset_req(dev_reset_req), .resume_req(resume_req)
    );

    task automatic check(string tag, string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 0; att_valid = 0; det_valid = 0; wake_valid = 0;
    endtask

    task automatic compare_all(string tag, int exp_rst[NP], int exp_res);
        check(tag, "resume_req", int'(resume_req), exp_res);
        for (int p = 0; p < NP; p++) check(tag, $sformatf("dev_reset_req[%0d]", p), int'(dev_reset_req[p]), exp_rst[p]);
        for (int idx = 0; idx <= NP; idx++) begin
            rd_port = IW'(idx);
            #1;
            check(tag, $sformatf("rd_data[%0d]", idx), int'(rd_data), (idx < NP) ? model[idx] : 'hFF7F);
        end
    endtask

    // One clock: model update from the held inputs, then compare at the falling edge.
    task automatic step(string tag);
        int exp_rst [NP];
        int exp_res;
        int v, wd;
        exp_res = 0;
        @(posedge clk);
        wd = int'(wr_data);
        for (int p = 0; p < NP; p++) begin
            v = model[p];
            exp_rst[p] = 0;
            if (wr_en && wr_port == IW'(p)) begin
                if (wd[9] && !v[9] && v[0]) exp_rst[p] = 1;
                for (int b = 0; b < 16; b++) begin
                    if (b == 1 || b == 3) begin
                        if (wd[b]) v[b] = 0;
                    end else if (!(b == 0 || b == 4 || b == 5 || b == 7 || b == 8)) begin
                        v[b] = wd[b];
                    end
                end
            end
            if (att_valid && att_port == IW'(p)) begin
                v[0] = 1; v[1] = 1; v[8] = att_low; exp_res = 1;
            end
            if (det_valid && det_port == IW'(p)) begin
                if (v[0]) begin v[0] = 0; v[1] = 1; end
                if (v[2]) begin v[2] = 0; v[3] = 1; end
                exp_res = 1;
            end
            if (wake_valid && wake_port == IW'(p) && v[12] && !v[6]) begin
                v[6] = 1; exp_res = 1;
            end
            model[p] = v & 'hFFFF;
        end
        @(negedge clk);
        compare_all(tag, exp_rst, exp_res);
        idle_inputs();
    endtask

    task automatic do_write(string tag, int port, int data);
        wr_en = 1; wr_port = IW'(port); wr_data = 16'(data);
        step(tag);
    endtask

    initial begin
        #4000000;
        if (!finished) begin
            compared++; mismatched++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int zero_rst [NP];
        for (int p = 0; p < NP; p++) begin model[p] = 'h0080; zero_rst[p] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare_all("R1", zero_rst, 0);
        rst_n = 1;
        step("R1");
        // R2: all ones, reset bit rises but no device present (R4 boundary)
        do_write("R2", 0, 'hFFFF);
        do_write("R2", 0, 'h0000);
        // R5: low-speed attach
        att_valid = 1; att_port = 0; att_low = 1; step("R5");
        // R3: writing 0 keeps the flag, writing 1 clears it
        do_write("R3", 0, 'h0000);
        do_write("R3", 0, 'h0002);
        // R4: edge of reset bit with device present
        do_write("R4", 0, 'h0200);
        do_write("R4", 0, 'h0200);
        do_write("R4", 0, 'h0000);
        do_write("R4", 0, 'h0204);
        // R7: wakeup without suspend is ignored, with suspend it takes once
        wake_valid = 1; wake_port = 0; step("R7");
        do_write("R7", 0, 'h1004);
        wake_valid = 1; wake_port = 0; step("R7");
        wake_valid = 1; wake_port = 0; step("R7");
        // R6: detach from enabled, then detach again
        det_valid = 1; det_port = 0; step("R6");
        det_valid = 1; det_port = 0; step("R6");
        do_write("R3", 0, 'h000A);
        // R8: out-of-range write and events
        do_write("R8", 5, 'hFFFF);
        att_valid = 1; att_port = 3; att_low = 1; step("R8");
        wake_valid = 1; wake_port = 2; step("R8");
        // R9: attach on port 1 while software clears the change flags
        wr_en = 1; wr_port = 1; wr_data = 16'h000A;
        att_valid = 1; att_port = 1; att_low = 1; step("R9");
        do_write("R9", 1, 'h0004);
        wr_en = 1; wr_port = 1; wr_data = 16'h000A;
        det_valid = 1; det_port = 1; step("R9");
        // R5: full-speed attach clears low-speed bit
        att_valid = 1; att_port = 1; att_low = 1; step("R5");
        att_valid = 1; att_port = 1; att_low = 0; step("R5");
        // Random mix
        for (int n = 0; n < 600; n++) begin
            wr_en      = ($urandom_range(0, 2) == 0);
            wr_port    = IW'($urandom_range(0, 3));
            wr_data    = 16'($urandom);
            att_valid  = ($urandom_range(0, 5) == 0);
            att_port   = IW'($urandom_range(0, 2));
            att_low    = 1'($urandom_range(0, 1));
            det_valid  = ($urandom_range(0, 5) == 0);
            det_port   = IW'($urandom_range(0, 2));
            wake_valid = ($urandom_range(0, 3) == 0);
            wake_port  = IW'($urandom_range(0, 2));
            if (att_valid && det_valid && att_port == det_port) det_valid = 0;
            step("R2");
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule